// File: doc/BRIEF.md
# Text-Mode Character Scanline Generator

This block turns a screen of 8-bit character codes into a serial stream of one-bit pixels for a character display. Each screen cell is drawn from an 8x8 glyph cell taken from a built-in font of 128 glyphs. The pixel rate is roughly 25 MHz in a VGA-class mode. The glyph data never has to be fetched within the time of a single pixel. On each line-start pulse the block fetches the codes of the whole requested display line through a synchronous read port. It looks up the matching glyph row of each code and packs the rows into one of two line buffers, as 32-bit words of four glyph bytes each.

The line that was prefetched before a line-start pulse is the one shown after it. While that line is shifted out, a fill of the other buffer runs at the same time. The display timing logic drives three inputs: a line-start pulse, a row number and an active-pixel enable. Sync generation, colour and cursor are left to other logic.

Top module: `txt_scanline_gen`

## Requirements
- R1: During and after reset, `pix_out` and `rd_en` are 0 until the first line-start pulse.
- R2: In the cycle after a `line_start` pulse that carries row r, `rd_en` is high for exactly COLS consecutive cycles. The addresses run from (r div 8)*COLS upward in steps of one. After that, `rd_en` stays low until the next pulse. `rd_data` is taken one cycle after its address.
- R3: For a code c in 32..127, the glyph byte for row g is ({c[6:0],0}) XOR {g,g,g[2:1]}, where g is a 3-bit value.
- R4: For a code c in 0..31, the glyph byte for row g is (0x80 >> g) XOR c[4:0]. This gives a built-in set of custom glyphs.
- R5: Bit 7 of `rd_data` has no effect on the pixels shown.
- R6: The glyph row used is the row number modulo 8.
- R7: The character fetched at column k supplies display pixels 8k to 8k+7, most significant glyph bit first.
- R8: The pixels after a `line_start` pulse come from the line requested at the previous pulse. The fill that runs at the same time does not change them.
- R9: `pix_out` is 0 in every cycle that follows a cycle with `pix_en` low. It is also 0 for enabled pixels past COLS*8 in a line.
- R10: The pixel index advances only on cycles with `pix_en` high. `pix_out` shows the pixel selected in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle pulse: swap buffers and start a fill |
| pix_en | input | 1 | Active-region pixel enable |
| row | input | ROW_W | Display line number to prefetch, sampled on `line_start` |
| rd_en | output | 1 | Character buffer read strobe |
| rd_addr | output | ADDR_W | Character buffer address |
| rd_data | input | 8 | Character code, one cycle after address |
| pix_out | output | 1 | Pixel stream |

## Verification
The bench builds the block with COLS=16, ROW_W=6 and ADDR_W=8, which gives four words per buffer and 128 pixels per line. With these values, every pixel of several full lines can be compared against the expected glyph bits, and so can the zeros past the line end. One screen row is filled with codes below 32, some of them with bit 7 set, so the custom glyphs and the code masking appear on real lines. Gaps in the pixel enable and fills that overlap the display exercise the pixel counter and the buffer swap.

// File: rtl/txt_scan_pkg.sv
// Package: shared sizes and the computed font for the text scanline generator.
// Assumes glyph cells of 8x8 pixels and four glyph bytes per packed word.
package txt_scan_pkg;

    localparam int GLYPH_PX  = 8;
    localparam int BYTES_PER_WORD = 4;

    // Glyph row byte for a 7-bit code and glyph row.
    function automatic logic [7:0] glyph_bits(input logic [6:0] code, input logic [2:0] g);
        logic [7:0] b;
        if (code < 7'd32)
            b = (8'h80 >> g) ^ {3'b000, code[4:0]};
        else
            b = {code, 1'b0} ^ {g, g, g[2:1]};
        return b;
    endfunction

endpackage

// File: rtl/txt_font_rom.sv
// Font lookup: maps a character code and a glyph row to 8 pixels.
// Assumes the upper code bit carries no meaning and drops it before lookup.
module txt_font_rom
    import txt_scan_pkg::*;
(
    input  logic [7:0] code,
    input  logic [2:0] glyph_row,
    output logic [7:0] bits
);

    // Drop bit 7, then look up the computed glyph row.
    always_comb begin
        bits = glyph_bits(code[6:0], glyph_row);
    end

endmodule

// File: rtl/txt_fetch.sv
// Line fetch engine: reads COLS codes for the requested line, one per cycle,
// and hands each glyph byte to the line store one cycle after its address.
// Assumes the character buffer returns data exactly one cycle after rd_en.
module txt_fetch #(
    parameter int COLS   = 80,
    parameter int ROW_W  = 10,
    parameter int ADDR_W = 13,
    localparam int COL_W = $clog2(COLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [ROW_W-1:0]  row,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [COL_W-1:0]  wr_col,
    output logic [7:0]        wr_byte
);

    logic              busy;
    logic [COL_W-1:0]  col;
    logic [ADDR_W-1:0] base;
    logic [2:0]        grow;
    logic              v_q;
    logic [COL_W-1:0]  c_q;

    // Sequence the column counter and latch line parameters on a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            col  <= '0;
            base <= '0;
            grow <= '0;
        end else if (line_start) begin
            busy <= 1'b1;
            col  <= '0;
            base <= ADDR_W'(32'(row >> 3) * COLS);
            grow <= row[2:0];
        end else if (busy) begin
            if (col == COL_W'(COLS - 1))
                busy <= 1'b0;
            col <= col + 1'b1;
        end
    end

    // Track which column the returning data belongs to; drop it on a new pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            c_q <= '0;
        end else begin
            v_q <= busy && !line_start;
            c_q <= col;
        end
    end

    assign rd_en   = busy;
    assign rd_addr = base + ADDR_W'(col);
    assign wr_en   = v_q;
    assign wr_col  = c_q;

    txt_font_rom u_font (
        .code      (rd_data),
        .glyph_row (grow),
        .bits      (wr_byte)
    );

    // R2
    fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> rd_en);

    // R2
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !line_start) |=> (!rd_en || rd_addr == $past(rd_addr) + ADDR_W'(1)));

endmodule

// File: rtl/txt_line_store.sv
// Double line store: one buffer fills from the fetch engine while the other
// supplies pixels; the roles swap on every line-start pulse.
// Assumes pix_idx stays below COLS*8 whenever its bit is used.
module txt_line_store #(
    parameter int COLS = 80,
    localparam int COL_W = $clog2(COLS + 1),
    localparam int WORDS = (COLS + 3) / 4,
    localparam int WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int PIX_W = $clog2(COLS * 8 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             wr_en,
    input  logic [COL_W-1:0] wr_col,
    input  logic [7:0]       wr_byte,
    input  logic [PIX_W-1:0] pix_idx,
    output logic             pix_bit
);

    logic [31:0]     lb [2][WORDS];
    logic            disp_sel;
    logic [WI_W-1:0] wr_w;
    logic [WI_W-1:0] rd_w;

    assign wr_w = WI_W'(wr_col >> 2);
    assign rd_w = WI_W'(pix_idx >> 5);

    // Swap display and fill roles on each line-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            disp_sel <= 1'b0;
        else if (line_start)
            disp_sel <= ~disp_sel;
    end

    // Place each glyph byte in its lane of the fill buffer, lane 0 at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int w = 0; w < WORDS; w++)
                    lb[b][w] <= '0;
        end else if (wr_en) begin
            lb[~disp_sel][wr_w][{~wr_col[1:0], 3'b000} +: 8] <= wr_byte;
        end
    end

    // Pick the current pixel from the display buffer, MSB of each word first.
    always_comb begin
        pix_bit = lb[disp_sel][rd_w][~pix_idx[4:0]];
    end

    // R8
    swap_only_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(disp_sel));

endmodule

// File: rtl/txt_scanline_gen.sv
// Top: text-mode scanline generator. Prefetches a line of glyph rows into a
// double line store and shifts one pixel out per enabled cycle.
// Assumes line_start and pix_en are never high in the same cycle.
module txt_scanline_gen #(
    parameter int COLS   = 80,
    parameter int ROW_W  = 10,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              pix_en,
    input  logic [ROW_W-1:0]  row,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              pix_out
);

    localparam int COL_W = $clog2(COLS + 1);
    localparam int TOTAL = COLS * 8;
    localparam int PIX_W = $clog2(TOTAL + 1);

    logic             wr_en;
    logic [COL_W-1:0] wr_col;
    logic [7:0]       wr_byte;
    logic [PIX_W-1:0] pix_cnt;
    logic             pix_bit;
    logic             in_line;

    txt_fetch #(.COLS(COLS), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .row        (row),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_col     (wr_col),
        .wr_byte    (wr_byte)
    );

    txt_line_store #(.COLS(COLS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .wr_en      (wr_en),
        .wr_col     (wr_col),
        .wr_byte    (wr_byte),
        .pix_idx    (pix_cnt),
        .pix_bit    (pix_bit)
    );

    assign in_line = (pix_cnt < PIX_W'(TOTAL));

    // Count enabled pixels within the line, restarting on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_cnt <= '0;
        else if (line_start)
            pix_cnt <= '0;
        else if (pix_en && in_line)
            pix_cnt <= pix_cnt + 1'b1;
    end

    // Register the pixel, blanking outside the active region and past line end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_out <= 1'b0;
        else
            pix_out <= pix_en && !line_start && in_line && pix_bit;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!pix_out && !rd_en));

    // R9
    blank_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> !pix_out);

endmodule

// File: tb/sim_txt_scanline_gen.sv
// Directed bench for the text scanline generator, one task per scenario.
module sim_txt_scanline_gen;

    localparam int COLS   = 16;
    localparam int ROW_W  = 6;
    localparam int ADDR_W = 8;
    localparam int TOTAL  = COLS * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_start = 1'b0;
    logic              pix_en = 1'b0;
    logic [ROW_W-1:0]  row = '0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data = '0;
    logic              pix_out;

    logic [7:0] mem [256];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    txt_scanline_gen #(.COLS(COLS), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_en(pix_en),
        .row(row), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pix_out(pix_out)
    );

    // Character buffer model with one cycle of read latency.
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected glyph byte, from R3/R4/R5.
    function automatic int exp_byte(input int code, input int g);
        int c = code % 128;
        if (c < 32) return ((128 >> g) ^ (c % 32)) & 255;
        return ((c * 2) ^ (g * 32 + g * 4 + g / 2)) & 255;
    endfunction

    // Expected pixel j of display line r (R6, R7, R9).
    function automatic int exp_pix(input int r, input int j);
        int code;
        if (j >= TOTAL) return 0;
        code = mem[(r / 8) * COLS + j / 8];
        return (exp_byte(code, r % 8) >> (7 - j % 8)) & 1;
    endfunction

    task automatic pulse(input int r);
        @(negedge clk);
        line_start = 1'b1;
        row = ROW_W'(r);
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 pix_out in reset", int'(pix_out), 0);
        chk("R1 rd_en in reset", int'(rd_en), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pix_out after reset", int'(pix_out), 0);
        chk("R1 rd_en after reset", int'(rd_en), 0);
    endtask

    // R2: read strobe and address sequence for one fill.
    task automatic t_fetch(input int r);
        @(negedge clk);
        line_start = 1'b1;
        row = ROW_W'(r);
        @(negedge clk);
        line_start = 1'b0;
        for (int k = 0; k < COLS; k++) begin
            chk("R2 rd_en", int'(rd_en), 1);
            chk("R2 rd_addr", int'(rd_addr), (r / 8) * COLS + k);
            @(negedge clk);
        end
        chk("R2 rd_en after fill", int'(rd_en), 0);
        repeat (2) @(negedge clk);
        chk("R2 rd_en still low", int'(rd_en), 0);
    endtask

    // R8/R10: show line 'shown' while the fill of line 'nxt' overlaps it.
    task automatic t_show(input int shown, input int nxt, input int gap, input string tag);
        int idx = 0;
        int p_idx = 0;
        bit p_en = 0;
        int cnt = 0;
        pulse(nxt);
        for (int c = 0; c <= TOTAL + 8 + (TOTAL + 8) / 3; c++) begin
            if (c > 0) begin
                chk(tag, int'(pix_out), p_en ? exp_pix(shown, p_idx) : 0);
            end
            p_en = (gap == 0) ? 1'b1 : ((c % gap) != gap - 1);
            if (c == TOTAL + 8 + (TOTAL + 8) / 3) p_en = 0;
            pix_en = p_en;
            if (p_en) begin
                p_idx = idx;
                idx++;
                cnt++;
            end
            @(negedge clk);
        end
        pix_en = 1'b0;
        @(negedge clk);
        chk("R9 idle after line", int'(pix_out), 0);
        repeat (COLS) @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'((a * 37 + 5) & 255);
        // Screen row 2: custom codes, odd ones with bit 7 set (R4, R5).
        for (int k = 0; k < COLS; k++) mem[2 * COLS + k] = 8'(k * 2 + ((k % 2) * 128));
        // Screen row 5: codes with and without bit 7 (R3, R5).
        for (int k = 0; k < COLS; k++) mem[5 * COLS + k] = 8'(40 + k * 5 + ((k % 3 == 0) ? 128 : 0));
        t_reset();
        t_fetch(5);
        t_show(5, 19, 0, "R7 line 5 pixels");
        t_show(19, 42, 4, "R4 R5 line 19 custom glyphs");
        t_show(42, 47, 3, "R3 R6 line 42 pixels");
        t_show(47, 0, 0, "R8 R10 line 47 pixels");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule